// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small bank of hardware lock tokens shared by two independent ports, called left and right. Each port has a select strobe, a write strobe, a latch address and a data bus. Software on either side claims a token by writing 0 on bit 0 of the data bus to the token's address. It then reads the same address to learn whether the claim succeeded. A read returns all zeros to the port that holds the token and all ones to everyone else. Writing 1 hands the token back.

Each port sees its own view of a token. A port that asks for a token the other side holds is not refused. Its request is remembered, and it is granted at the clock edge on which the holder lets go. When both ports ask for a free token in the same cycle, the left port gets it and the right port's request stays waiting. Writes take effect at the rising clock edge. Read data is combinational from the current state, so a read in the cycle after a write already shows the result of that write.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free, so both ports read all ones at every address.
- R2: Read data is a single ownership bit copied onto every bit of the bus: all zeros when the reading port holds the addressed token, otherwise all ones.
- R3: A write of 0 (data bit 0 low) by a port to a free token gives that port the token at the next rising edge. From then on that port reads 0 at that address and the other port reads 1.
- R4: A write happens only when select and write strobe are both low in the same cycle. With either one high, the tokens do not change.
- R5: Only data bit 0 of a write matters. The other data bits have no effect on the result.
- R6: A write of 1 by the holder frees the token at the next rising edge, unless a request is waiting (see R8).
- R7: A write of 1 by the port that does not hold the token leaves the holder unchanged. It also cancels any request that port has waiting on that token.
- R8: A write of 0 to a token held by the other port is kept as a waiting request. At the edge on which the holder releases, the token passes directly to the waiting port.
- R9: When both ports write 0 to the same free token in the same cycle, the left port gets it and the right port's request waits, as in R8.
- R10: Tokens are independent. An operation on one address never changes any other token.
- R11: At most one port holds a given token at any time. If both ports read the same address, at most one of them sees 0.
- R12: A port whose select is high reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left token select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W (3) | Left token address |
| l_wdata | input | DATA_W (9) | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W (9) | Left view of the addressed token |
| r_sel_n | input | 1 | Right token select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W (3) | Right token address |
| r_wdata | input | DATA_W (9) | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W (9) | Right view of the addressed token |

## Verification
Because read data comes straight from the stored holder, a wrong holder shows on the very next read of that address, in the cycle right after the faulty edge. A lost or stale waiting request stays hidden while the token is held. It appears only at the release edge, when the token either fails to pass to the waiting port or passes to a port that withdrew. For that reason, every waiting-request case is checked on the cycle just after a release, from both sides.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   want_l;
        logic   want_r;
    } cell_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int ADDR_W  = 3,
    parameter int NUM_SEM = 8
) (
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit0,
    output logic [NUM_SEM-1:0] take_vec,
    output logic [NUM_SEM-1:0] drop_vec
);

    logic wr_active;

    assign wr_active = ~sel_n & ~wr_n;

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        logic hit;
        assign hit         = wr_active & (addr == ADDR_W'(i));
        assign take_vec[i] = hit & ~bit0;
        assign drop_vec[i] = hit & bit0;
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_take,
    input  logic l_drop,
    input  logic r_take,
    input  logic r_drop,
    output logic own_l,
    output logic own_r
);

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d        = cell_q;
        cell_d.want_l = (cell_q.want_l | l_take) & ~l_drop;
        cell_d.want_r = (cell_q.want_r | r_take) & ~r_drop;

        if (cell_q.owner == OWN_LEFT && !cell_d.want_l) begin
            cell_d.owner = OWN_NONE;
        end else if (cell_q.owner == OWN_RIGHT && !cell_d.want_r) begin
            cell_d.owner = OWN_NONE;
        end

        if (cell_d.owner == OWN_NONE) begin
            if (cell_d.want_l) begin
                cell_d.owner = OWN_LEFT;
            end else if (cell_d.want_r) begin
                cell_d.owner = OWN_RIGHT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '{owner: OWN_NONE, want_l: 1'b0, want_r: 1'b0};
        end else begin
            cell_q <= cell_d;
        end
    end

    assign own_l = (cell_q.owner == OWN_LEFT);
    assign own_r = (cell_q.owner == OWN_RIGHT);

endmodule

// File: rtl/sem_view.sv
module sem_view #(
    parameter int ADDR_W  = 3,
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9
) (
    input  logic               sel_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);

    logic held;

    assign held  = own_vec[addr];
    assign rdata = sel_n ? {DATA_W{1'b1}} : {DATA_W{~held}};

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int NUM_SEM = 1 << ADDR_W;

    logic [NUM_SEM-1:0] l_take, l_drop, r_take, r_drop;
    logic [NUM_SEM-1:0] own_l_vec, own_r_vec;
    logic               unused_hi_bits;

    assign unused_hi_bits = ^{l_wdata, r_wdata};

    sem_port_decode #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM)) u_dec_l (
        .sel_n    (l_sel_n),
        .wr_n     (l_wr_n),
        .addr     (l_addr),
        .bit0     (l_wdata[0]),
        .take_vec (l_take),
        .drop_vec (l_drop)
    );

    sem_port_decode #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM)) u_dec_r (
        .sel_n    (r_sel_n),
        .wr_n     (r_wr_n),
        .addr     (r_addr),
        .bit0     (r_wdata[0]),
        .take_vec (r_take),
        .drop_vec (r_drop)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_take (l_take[i]),
            .l_drop (l_drop[i]),
            .r_take (r_take[i]),
            .r_drop (r_drop[i]),
            .own_l  (own_l_vec[i]),
            .own_r  (own_r_vec[i])
        );
    end

    sem_view #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_view_l (
        .sel_n   (l_sel_n),
        .addr    (l_addr),
        .own_vec (own_l_vec),
        .rdata   (l_rdata)
    );

    sem_view #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_view_r (
        .sel_n   (r_sel_n),
        .addr    (r_addr),
        .own_vec (own_r_vec),
        .rdata   (r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 9,
    parameter int NUM_SEM = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel_n,
    input logic               l_wr_n,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel_n,
    input logic               r_wr_n,
    input logic [ADDR_W-1:0]  r_addr,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l_vec,
    input logic [NUM_SEM-1:0] own_r_vec
);

    // R11: both ports reading one address never both see ownership
    p_mutex_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && !r_sel_n && l_addr == r_addr) |-> (l_rdata[0] | r_rdata[0]));

    // R12: deselected port reads all ones
    p_idle_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
        l_sel_n |-> (&l_rdata));

    // R2: every read bit equals bit 0
    p_bit_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rdata == {DATA_W{r_rdata[0]}}));

    // R3: left request on a free token wins at the next edge
    p_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && !l_wr_n && !l_wdata[0] && !own_l_vec[l_addr] && !own_r_vec[l_addr])
        |=> own_l_vec[$past(l_addr)]);

    // R4: no write strobe on either side keeps every token holder unchanged
    p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_sel_n || l_wr_n) && (r_sel_n || r_wr_n))
        |=> ($stable(own_l_vec) && $stable(own_r_vec)));

    // R6: left holder writing 1 no longer holds at the next edge
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && !l_wr_n && l_wdata[0] && own_l_vec[l_addr])
        |=> !own_l_vec[$past(l_addr)]);

endmodule

bind sem_bank sem_bank_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_SEM (NUM_SEM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .l_sel_n   (l_sel_n),
    .l_wr_n    (l_wr_n),
    .l_addr    (l_addr),
    .l_wdata   (l_wdata),
    .l_rdata   (l_rdata),
    .r_sel_n   (r_sel_n),
    .r_wr_n    (r_wr_n),
    .r_addr    (r_addr),
    .r_rdata   (r_rdata),
    .own_l_vec (own_l_vec),
    .own_r_vec (own_r_vec)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 9;
    localparam logic [DATA_W-1:0] ONES  = '1;
    localparam logic [DATA_W-1:0] ZEROS = '0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l_sel_n = 1'b1, l_wr_n = 1'b1;
    logic [ADDR_W-1:0] l_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0;
    logic [DATA_W-1:0] l_rdata;
    logic              r_sel_n = 1'b1, r_wr_n = 1'b1;
    logic [ADDR_W-1:0] r_addr = '0;
    logic [DATA_W-1:0] r_wdata = '0;
    logic [DATA_W-1:0] r_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [DATA_W-1:0] exp_q[$];
    bit                side_q[$];
    string             tag_q[$];

    always #4 clk = ~clk;

    sem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // monitor: compare mid low phase, after the driver has set inputs
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            logic [DATA_W-1:0] a;
            bit                s;
            string             t;
            e = exp_q.pop_front();
            s = side_q.pop_front();
            t = tag_q.pop_front();
            a = s ? r_rdata : l_rdata;
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s side=%s actual=%h expected=%h", t, s ? "R" : "L", a, e);
            end
        end
    end

    task automatic idle_all();
        l_sel_n = 1'b1; l_wr_n = 1'b1;
        r_sel_n = 1'b1; r_wr_n = 1'b1;
    endtask

    // one cycle of writes; a side with en=0 stays idle
    task automatic wr(input bit l_en, input logic [ADDR_W-1:0] la, input logic [DATA_W-1:0] ld,
                      input bit r_en, input logic [ADDR_W-1:0] ra, input logic [DATA_W-1:0] rd);
        @(negedge clk);
        idle_all();
        if (l_en) begin l_sel_n = 1'b0; l_wr_n = 1'b0; l_addr = la; l_wdata = ld; end
        if (r_en) begin r_sel_n = 1'b0; r_wr_n = 1'b0; r_addr = ra; r_wdata = rd; end
    endtask

    // one cycle of a read on one side, expected value queued for the monitor
    task automatic rd(input bit side, input bit sel_n, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] e, input string tag);
        @(negedge clk);
        idle_all();
        if (side) begin r_sel_n = sel_n; r_addr = a; end
        else      begin l_sel_n = sel_n; l_addr = a; end
        exp_q.push_back(e);
        side_q.push_back(side);
        tag_q.push_back(tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(1'b0, 1'b0, ADDR_W'(a), ONES, "R1 left free after reset");
            rd(1'b1, 1'b0, ADDR_W'(a), ONES, "R1 right free after reset");
        end

        // R3 / R2 left claims token 2
        wr(1'b1, 3'd2, ZEROS, 1'b0, 3'd0, ZEROS);
        rd(1'b0, 1'b0, 3'd2, ZEROS, "R3 R2 left holds token 2");
        rd(1'b1, 1'b0, 3'd2, ONES,  "R3 right sees token 2 taken");
        // R12 deselected port reads ones even while it holds a token
        rd(1'b0, 1'b1, 3'd2, ONES,  "R12 deselected left");
        // R10 neighbours untouched
        rd(1'b0, 1'b0, 3'd1, ONES,  "R10 token 1 untouched");
        rd(1'b0, 1'b0, 3'd3, ONES,  "R10 token 3 untouched");

        // R4 write strobe without select
        @(negedge clk); idle_all(); l_sel_n = 1'b1; l_wr_n = 1'b0; l_addr = 3'd3; l_wdata = ZEROS;
        rd(1'b0, 1'b0, 3'd3, ONES, "R4 no claim without select");
        // R4 select without write strobe (read only)
        @(negedge clk); idle_all(); l_sel_n = 1'b0; l_wr_n = 1'b1; l_addr = 3'd3; l_wdata = ZEROS;
        rd(1'b0, 1'b0, 3'd3, ONES, "R4 no claim without write strobe");

        // R5 upper data bits ignored: right claims 5 with upper bits high
        wr(1'b0, 3'd0, ZEROS, 1'b1, 3'd5, 9'h1FE);
        rd(1'b1, 1'b0, 3'd5, ZEROS, "R5 claim with bit0 low");
        wr(1'b0, 3'd0, ZEROS, 1'b1, 3'd5, 9'h001);
        rd(1'b1, 1'b0, 3'd5, ONES,  "R5 R6 release with bit0 high");
        rd(1'b0, 1'b0, 3'd5, ONES,  "R6 token 5 free for left");

        // R7 non-holder writes 1: left keeps token 2
        wr(1'b0, 3'd0, ZEROS, 1'b1, 3'd2, ONES);
        rd(1'b0, 1'b0, 3'd2, ZEROS, "R7 holder kept after foreign release");

        // R8 right waits on token 2, left releases, token passes
        wr(1'b0, 3'd0, ZEROS, 1'b1, 3'd2, ZEROS);
        rd(1'b1, 1'b0, 3'd2, ONES,  "R8 waiting right not yet holder");
        wr(1'b1, 3'd2, ONES, 1'b0, 3'd0, ZEROS);
        rd(1'b1, 1'b0, 3'd2, ZEROS, "R8 token passed to waiting right");
        rd(1'b0, 1'b0, 3'd2, ONES,  "R8 left no longer holds");

        // R7 withdrawal: left waits then cancels, right releases -> free
        wr(1'b1, 3'd2, ZEROS, 1'b0, 3'd0, ZEROS);
        wr(1'b1, 3'd2, ONES,  1'b0, 3'd0, ZEROS);
        wr(1'b0, 3'd0, ZEROS, 1'b1, 3'd2, ONES);
        rd(1'b0, 1'b0, 3'd2, ONES, "R7 cancelled request not granted");
        rd(1'b1, 1'b0, 3'd2, ONES, "R7 token 2 free after withdrawal");

        // R9 same-cycle claim on token 6
        wr(1'b1, 3'd6, ZEROS, 1'b1, 3'd6, ZEROS);
        rd(1'b0, 1'b0, 3'd6, ZEROS, "R9 left wins tie");
        rd(1'b1, 1'b0, 3'd6, ONES,  "R9 right loses tie");
        wr(1'b1, 3'd6, ONES, 1'b0, 3'd0, ZEROS);
        rd(1'b1, 1'b0, 3'd6, ZEROS, "R9 R8 right granted after left release");

        // R11 both read token 6 in one cycle: exactly right holds
        @(negedge clk); idle_all();
        l_sel_n = 1'b0; l_addr = 3'd6; r_sel_n = 1'b0; r_addr = 3'd6;
        #2;
        total++;
        if (!(l_rdata == ONES && r_rdata == ZEROS)) begin
            bad++;
            $display("FAIL R11 actual=%h/%h expected=%h/%h", l_rdata, r_rdata, ONES, ZEROS);
        end

        // R10 simultaneous claims on different tokens
        wr(1'b1, 3'd0, ZEROS, 1'b1, 3'd7, ZEROS);
        rd(1'b0, 1'b0, 3'd0, ZEROS, "R10 left holds 0");
        rd(1'b1, 1'b0, 3'd7, ZEROS, "R10 right holds 7");
        rd(1'b1, 1'b0, 3'd0, ONES,  "R10 right not holding 0");

        rd(1'b0, 1'b1, 3'd0, ONES, "R12 final idle");
        @(negedge clk); idle_all();
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule